// File: doc/BRIEF.md
# Edge-Triggered Wakeup Line Controller

This block watches a bank of asynchronous wakeup lines and turns their transitions into interrupt requests and event pulses. Each line passes through a two-stage synchroniser. Its synchronised value is compared with the value from the previous cycle to find rising and falling transitions. Software picks, per line, which transition directions count as a trigger. A trigger sets a sticky pending bit. The pending bit, qualified by a per-line interrupt mask, drives the interrupt output. The same trigger also produces a one-cycle event pulse, qualified by a per-line event mask. The event pulse does not depend on the pending bit.

Software configures the block over a simple register bus with byte addresses. The bus has a write strobe and a read strobe, and read data is registered. A pending bit is cleared by writing 1 to its position in the pending register. A trigger that lands in the same cycle as that clear wins, so the bit stays set. A rising transition that is detected in the same cycle as a write to the rising-enable register is discarded.

Top module: `lxc_line_ctrl`

## Requirements
- R1: After synchronous reset, every configuration register and every pending bit is zero, and irq_out and evt_out are all zero.
- R2: When a line's rising enable is 1, a 0-to-1 change on line_in sets that line's pending bit at the third rising clock edge after the change. It is not set at the second edge.
- R3: When a line's falling enable is 1, a 1-to-0 change on line_in sets that line's pending bit with the same three-edge latency.
- R4: When both enables are set on one line, a rising change and a falling change each set pending.
- R5: A line held at a constant level never sets pending. A transition whose direction is not enabled never sets pending.
- R6: A rising transition that is detected in the same cycle as a bus write to the rising-enable register (offset 0x28) sets neither pending nor evt_out for that line.
- R7: Writing 1 to a bit of the pending register (offset 0x30) clears that bit. Writing 0 to a bit leaves it unchanged.
- R8: When a trigger and a clear of the same pending bit happen in the same cycle, the bit ends up set.
- R9: irq_out[i] equals pending[i] AND interrupt-mask[i]. Clearing a mask bit hides the request but keeps the pending bit.
- R10: evt_out[i] pulses high for exactly one cycle, in the cycle pending would be set, when event-mask[i] is 1. It stays low when event-mask[i] is 0. It pulses whether or not pending[i] is already set.
- R11: The register offsets are: interrupt mask 0x20, event mask 0x24, rising enable 0x28, falling enable 0x2C, pending 0x30. Line i sits at bit i. A read strobe returns the data on bus_rdata after the next clock edge. Bits at or above NUM_LINES read as zero and ignore writes. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_LINES | Asynchronous wakeup lines |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | NUM_LINES | Masked pending interrupt request per line |
| evt_out | output | NUM_LINES | One-cycle event pulse per line |

## Verification
Two kinds of internal fault show up at the ports in different ways. A stale pending bit appears on irq_out as soon as its mask bit is set, and it can also be read back on the next read strobe. A wrong edge detector or synchroniser shows up as a trigger one edge too early or too late, or as a missing or repeated evt_out pulse. The bench therefore samples evt_out at the exact edge where it is due and again one edge later. The collision and clear-versus-set cases are each aligned to a single cycle. A mistake in which term takes priority changes the pending readback right away.

// File: rtl/lxc_pkg.sv
package lxc_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IMASK,
    SEL_EMASK,
    SEL_RISE,
    SEL_FALL,
    SEL_PEND
  } reg_sel_e;

  localparam logic [7:0] OFS_IMASK = 8'h20;
  localparam logic [7:0] OFS_EMASK = 8'h24;
  localparam logic [7:0] OFS_RISE  = 8'h28;
  localparam logic [7:0] OFS_FALL  = 8'h2C;
  localparam logic [7:0] OFS_PEND  = 8'h30;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_IMASK: return SEL_IMASK;
      OFS_EMASK: return SEL_EMASK;
      OFS_RISE:  return SEL_RISE;
      OFS_FALL:  return SEL_FALL;
      OFS_PEND:  return SEL_PEND;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lxc_sync.sv
module lxc_sync #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] din,
  output logic [NUM_LINES-1:0] dout
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/lxc_edge.sv
module lxc_edge #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] cur,
  output logic [NUM_LINES-1:0] rise,
  output logic [NUM_LINES-1:0] fall
);

  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur;
  end

  always_comb begin
    rise = cur & ~prev_q;
    fall = ~cur & prev_q;
  end

endmodule

// File: rtl/lxc_regs.sv
module lxc_regs #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 re,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] pend,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] imask,
  output logic [NUM_LINES-1:0] emask,
  output logic [NUM_LINES-1:0] rise_en,
  output logic [NUM_LINES-1:0] fall_en,
  output logic                 rise_wr,
  output logic [NUM_LINES-1:0] clr_bits
);

  import lxc_pkg::*;

  reg_sel_e             sel;
  logic [NUM_LINES-1:0] wbits;

  always_comb begin
    sel      = decode_ofs(8'(addr));
    wbits    = wdata[NUM_LINES-1:0];
    rise_wr  = we && (sel == SEL_RISE);
    clr_bits = (we && (sel == SEL_PEND)) ? wbits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imask   <= '0;
      emask   <= '0;
      rise_en <= '0;
      fall_en <= '0;
    end else if (we) begin
      case (sel)
        SEL_IMASK: imask   <= wbits;
        SEL_EMASK: emask   <= wbits;
        SEL_RISE:  rise_en <= wbits;
        SEL_FALL:  fall_en <= wbits;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      case (sel)
        SEL_IMASK: rdata <= DATA_W'(imask);
        SEL_EMASK: rdata <= DATA_W'(emask);
        SEL_RISE:  rdata <= DATA_W'(rise_en);
        SEL_FALL:  rdata <= DATA_W'(fall_en);
        SEL_PEND:  rdata <= DATA_W'(pend);
        default:   rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/lxc_line_ctrl.sv
module lxc_line_ctrl #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_out,
  output logic [NUM_LINES-1:0] evt_out
);

  logic [NUM_LINES-1:0] sync_val, rise, fall;
  logic [NUM_LINES-1:0] imask, emask, rise_en, fall_en, clr_bits;
  logic                 rise_wr;
  logic [NUM_LINES-1:0] trig, pend_q, evt_q;

  lxc_sync #(.NUM_LINES(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(line_in), .dout(sync_val)
  );

  lxc_edge #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk(clk), .rst(rst), .cur(sync_val), .rise(rise), .fall(fall)
  );

  lxc_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .pend(pend_q), .rdata(bus_rdata), .imask(imask),
    .emask(emask), .rise_en(rise_en), .fall_en(fall_en), .rise_wr(rise_wr),
    .clr_bits(clr_bits)
  );

  // A rising trigger is discarded while software rewrites the rising enables.
  always_comb begin
    trig = (rise & rise_en & ~{NUM_LINES{rise_wr}}) | (fall & fall_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_bits) | trig;
      evt_q  <= trig & emask;
    end
  end

  assign irq_out = pend_q & imask;
  assign evt_out = evt_q;

  AST_NO_SPONT_PEND: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~$past(pend_q) & ~$past(rise | fall)) == '0)); // R5
  AST_RISE_WR_DROP: assert property (@(posedge clk) disable iff (rst)
    $past(rise_wr) |-> ((pend_q & ~$past(pend_q) & $past(rise)) == '0)); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & $past(clr_bits) & ~$past(rise | fall)) == '0)); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (($past(rise & rise_en & ~{NUM_LINES{rise_wr}}) & ~pend_q) == '0)); // R8
  AST_EVT_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    ((evt_out & ~$past(rise | fall)) == '0)); // R10

endmodule

// File: tb/tb_lxc_line_ctrl.sv
module tb_lxc_line_ctrl;

  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  line_in = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_out, evt_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [7:0] A_IM = 8'h20, A_EM = 8'h24, A_RI = 8'h28,
                         A_FA = 8'h2C, A_PE = 8'h30;

  always #5 clk = ~clk;

  lxc_line_ctrl #(.NUM_LINES(N), .ADDR_W(8), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .line_in(line_in), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .evt_out(evt_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    step();
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic drive_line(input int i, input logic v);
    line_in[i] = v;
    repeat (3) step();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 evt", 32'(evt_out), 0);
    rd(A_IM, d); chk("R1 imask", d, 0);
    rd(A_EM, d); chk("R1 emask", d, 0);
    rd(A_RI, d); chk("R1 rise", d, 0);
    rd(A_FA, d); chk("R1 fall", d, 0);
    rd(A_PE, d); chk("R1 pend", d, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(A_IM, 32'hFFFF_FFFF);
    rd(A_IM, d); chk("R11 reserved bits", d, 32'h0000_00FF);
    wr(A_EM, 32'h0000_01A5);
    rd(A_EM, d); chk("R11 emask", d, 32'h0000_00A5);
    rd(8'h3C, d); chk("R11 unmapped", d, 0);
    wr(A_IM, 0);
    wr(A_EM, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(A_IM, 32'h01); wr(A_EM, 32'h01); wr(A_RI, 32'h01);
    line_in[0] = 1'b1;
    step(); step();
    chk("R2 not yet", 32'(evt_out), 0);
    step();
    chk("R10 evt pulse", 32'(evt_out), 32'h01);
    chk("R2 irq set", 32'(irq_out), 32'h01);
    step();
    chk("R10 one cycle", 32'(evt_out), 0);
    rd(A_PE, d); chk("R2 pend read", d, 32'h01);
    wr(A_PE, 32'h01);
    repeat (5) step();
    chk("R5 level held", 32'(irq_out), 0);
  endtask

  task automatic t_fall();
    wr(A_FA, 32'h02); wr(A_IM, 32'h02);
    drive_line(1, 1'b1);
    chk("R5 disabled direction", 32'(irq_out), 0);
    drive_line(1, 1'b0);
    chk("R3 falling sets", 32'(irq_out), 32'h02);
    wr(A_PE, 32'h02);
  endtask

  task automatic t_both();
    wr(A_RI, 32'h05); wr(A_FA, 32'h06); wr(A_IM, 32'h04);
    drive_line(2, 1'b1);
    chk("R4 rise", 32'(irq_out), 32'h04);
    wr(A_PE, 32'h04);
    chk("R4 cleared", 32'(irq_out), 0);
    drive_line(2, 1'b0);
    chk("R4 fall", 32'(irq_out), 32'h04);
    wr(A_PE, 32'h04);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    wr(A_RI, 32'h0D); wr(A_EM, 32'h08); wr(A_IM, 32'h08);
    line_in[3] = 1'b1;
    step(); step();
    wr(A_RI, 32'h0D);
    chk("R6 evt dropped", 32'(evt_out), 0);
    chk("R6 irq dropped", 32'(irq_out), 0);
    rd(A_PE, d); chk("R6 pend dropped", d, 0);
    drive_line(3, 1'b0);
    line_in[3] = 1'b1;
    step(); step(); step();
    chk("R6 control edge", 32'(irq_out), 32'h08);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_PE, 32'h00);
    rd(A_PE, d); chk("R7 write zero", d, 32'h08);
    drive_line(3, 1'b0);
    line_in[3] = 1'b1;
    step(); step();
    wr(A_PE, 32'h08);
    rd(A_PE, d); chk("R8 set wins", d, 32'h08);
    wr(A_PE, 32'h08);
    rd(A_PE, d); chk("R7 clear", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_IM, 0); wr(A_EM, 0);
    drive_line(3, 1'b0);
    drive_line(3, 1'b1);
    chk("R10 event masked", 32'(evt_out), 0);
    chk("R9 irq masked", 32'(irq_out), 0);
    rd(A_PE, d); chk("R9 pend kept", d, 32'h08);
    wr(A_IM, 32'h08);
    chk("R9 unmask", 32'(irq_out), 32'h08);
    wr(A_EM, 32'h08);
    drive_line(3, 1'b0);
    drive_line(3, 1'b1);
    chk("R10 evt with pend set", 32'(evt_out), 32'h08);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_regmap();
    t_rise();
    t_fall();
    t_both();
    t_collision();
    t_clear();
    t_mask();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule